// File: doc/BRIEF.md
# Queued Microcoded Pattern Sequencer

This block steps through short microprograms held in a small on-chip program memory, one instruction per clock cycle. Its purpose is to generate timed output patterns, such as the phase steps of a stepper motor or a fixed command ritual for a memory device. Every instruction holds a 3-bit operation code in its top bits. The remaining low bits form a data field. An emit instruction places that field on the output port for one cycle.

The block has no general registers. Repeat counts and return addresses live on one internal last-in-first-out stack, and the program fills that stack itself with push instructions. Other logic starts a routine by writing its start address into an entry queue. Several routines can share one program memory this way. When a routine executes its finish instruction, the next queued address is loaded in that same cycle, so queued routines follow each other with no gap. When the queue is empty at that point, the sequencer goes idle and keeps its last output value.

The program memory is filled through a simple write port before any routine is queued.

Top module: `seq_core`

## Requirements
- R1: After a synchronous reset, `idle` is 1 and `out_valid`, `out_data`, `err` and `entry_full` are 0. The stack and the entry queue are empty.
- R2: An instruction word is {op[2:0], data}, where op sits in the top 3 bits and data fills the low INSTR_W-3 bits. Op 0 (emit) sets `out_data` to data and `out_valid` to 1 in the cycle after the emit executes. In every other cycle `out_valid` is 0 and `out_data` holds its value.
- R3: Op 1 pushes data onto the stack. Op 2 (loop) looks at the top of the stack. If top-1 is nonzero, it replaces the top with top-1 and jumps to the address in the low bits of data. Otherwise it pops the stack and falls through to the next address. The stack never holds more than STACK_DEPTH entries.
- R4: Op 3 jumps to the absolute address held in the low bits of data.
- R5: Op 4 (call) pushes the address of the next instruction and then jumps to data. Op 5 (return) pops that value and continues from it. Op 6 pops the stack and discards the value.
- R6: The sequencer executes exactly one instruction per cycle while running. When op 7 (finish) executes and the queue is not empty, the first instruction of the next queued routine executes in the very next cycle. When the queue is empty, `idle` is 1 from the next cycle on.
- R7: An entry address written while the sequencer is idle is stored at the next clock edge and loaded at the edge after that. The routine's first instruction therefore executes in the second cycle after the write.
- R8: The entry queue holds FIFO_DEPTH addresses. `entry_full` is 1 while it is full, and a write made while it is full is dropped.
- R9: A push or call on a full stack (overflow), or a loop, return or pop on an empty stack (underflow), sets `err`. Once set, `err` stays 1 until reset. Routines without such a fault never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Write enable for the program memory |
| prog_addr | input | $clog2(ROM_DEPTH) | Program memory write address |
| prog_data | input | INSTR_W | Instruction word to write |
| entry_push | input | 1 | Queue a routine start address |
| entry_addr | input | $clog2(ROM_DEPTH) | Start address to queue |
| entry_full | output | 1 | Entry queue is full |
| out_data | output | INSTR_W-3 | Last emitted data field |
| out_valid | output | 1 | High for one cycle per emit |
| idle | output | 1 | No routine is executing |
| err | output | 1 | Sticky stack fault flag |

## Verification
The checker asserts the local rules on every cycle. Data changes only with `out_valid`, and no emit appears while idle. A finish instruction moves to running or to idle according to the queue state, and a start from idle happens one cycle after an entry is waiting. The full flag survives a write made while full, the stack count stays bounded, and `err` is set after a fault and stays set. Only the bench's scenarios can show that whole routines produce the right phase values at the right cycle offsets. They also cover loop counts from 1 to 6, back-to-back handoff across five queued routines, the dropped write on a full queue, and both fault kinds.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_EMIT = 3'd0,
    OP_PUSH = 3'd1,
    OP_LOOP = 3'd2,
    OP_JMP  = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_POP  = 3'd6,
    OP_END  = 3'd7
  } seq_op_e;
endpackage

// File: rtl/seq_entry_fifo.sv
module seq_entry_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_top,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] sp;
  logic [IW-1:0] top_idx;

  assign top_idx = IW'(sp - CW'(1));
  assign empty   = (sp == '0);
  assign full    = (sp == CW'(DEPTH));
  assign count   = sp;
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full)        mem[IW'(sp)] <= wdata;
    else if (wr_top && !empty) mem[top_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                  sp <= '0;
    else if (push && !full)   sp <= sp + CW'(1);
    else if (pop && !empty)   sp <= sp - CW'(1);
  end
endmodule

// File: rtl/seq_prog_mem.sv
module seq_prog_mem #(
  parameter int W     = 12,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int INSTR_W     = 12,
  parameter int ROM_DEPTH   = 32,
  parameter int STACK_DEPTH = 4,
  parameter int FIFO_DEPTH  = 8,
  localparam int AW         = $clog2(ROM_DEPTH),
  localparam int DATA_W     = INSTR_W - OPC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               entry_push,
  input  logic [AW-1:0]      entry_addr,
  output logic               entry_full,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_valid,
  output logic               idle,
  output logic               err
);
  localparam int SCW = $clog2(STACK_DEPTH + 1);

  logic [AW-1:0]      pc, pc_nx;
  logic               running;
  logic [INSTR_W-1:0] instr;
  seq_op_e            op;
  logic [DATA_W-1:0]  d;
  logic [AW-1:0]      tgt;

  logic               fifo_pop, fifo_empty, fifo_full;
  logic [AW-1:0]      fifo_head;

  logic               stk_push, stk_pop, stk_wr;
  logic [DATA_W-1:0]  stk_wdata, stk_top;
  logic [SCW-1:0]     stk_count;
  logic               stk_empty, stk_full;

  // named events for the checker
  logic               emit, is_end, ev_overflow, ev_underflow;

  function automatic logic loop_again(input logic [DATA_W-1:0] v);
    return (v - DATA_W'(1)) != '0;
  endfunction

  function automatic logic [DATA_W-1:0] ret_addr(input logic [AW-1:0] p);
    return DATA_W'(p + AW'(1));
  endfunction

  seq_prog_mem #(.W(INSTR_W), .DEPTH(ROM_DEPTH)) u_prog (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc), .rdata(instr)
  );

  seq_entry_fifo #(.W(AW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(entry_push), .wdata(entry_addr),
    .pop(fifo_pop), .rdata(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  seq_stack #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop), .wr_top(stk_wr),
    .wdata(stk_wdata), .top(stk_top), .count(stk_count),
    .empty(stk_empty), .full(stk_full)
  );

  assign op  = seq_op_e'(instr[INSTR_W-1 -: OPC_W]);
  assign d   = instr[DATA_W-1:0];
  assign tgt = d[AW-1:0];

  always_comb begin
    pc_nx        = pc + AW'(1);
    stk_push     = 1'b0;
    stk_pop      = 1'b0;
    stk_wr       = 1'b0;
    stk_wdata    = d;
    emit         = 1'b0;
    is_end       = 1'b0;
    ev_overflow  = 1'b0;
    ev_underflow = 1'b0;
    if (running) begin
      unique case (op)
        OP_EMIT: emit = 1'b1;
        OP_PUSH: begin
          if (stk_full) ev_overflow = 1'b1;
          else          stk_push    = 1'b1;
        end
        OP_LOOP: begin
          if (stk_empty) ev_underflow = 1'b1;
          else if (loop_again(stk_top)) begin
            stk_wr    = 1'b1;
            stk_wdata = stk_top - DATA_W'(1);
            pc_nx     = tgt;
          end else stk_pop = 1'b1;
        end
        OP_JMP: pc_nx = tgt;
        OP_CALL: begin
          pc_nx = tgt;
          if (stk_full) ev_overflow = 1'b1;
          else begin
            stk_push  = 1'b1;
            stk_wdata = ret_addr(pc);
          end
        end
        OP_RET: begin
          if (stk_empty) ev_underflow = 1'b1;
          else begin
            stk_pop = 1'b1;
            pc_nx   = stk_top[AW-1:0];
          end
        end
        OP_POP: begin
          if (stk_empty) ev_underflow = 1'b1;
          else           stk_pop      = 1'b1;
        end
        OP_END: is_end = 1'b1;
      endcase
    end
    fifo_pop = (!running || is_end) && !fifo_empty;
    if (fifo_pop) pc_nx = fifo_head;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      running   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      err       <= 1'b0;
    end else begin
      if (running || fifo_pop) pc <= pc_nx;
      if (fifo_pop)    running <= 1'b1;
      else if (is_end) running <= 1'b0;
      out_valid <= emit;
      if (emit) out_data <= d;
      if (ev_overflow || ev_underflow) err <= 1'b1;
    end
  end

  assign idle       = !running;
  assign entry_full = fifo_full;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int STACK_DEPTH = 4,
  parameter int DATA_W      = 9,
  localparam int SCW        = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              idle,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              err,
  input logic              entry_full,
  input logic              fifo_pop,
  input logic              fifo_empty,
  input logic              is_end,
  input logic              ev_overflow,
  input logic              ev_underflow,
  input logic [SCW-1:0]    stk_count
);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  assert_stack_bound_R3: assert property (@(posedge clk) disable iff (rst)
    stk_count <= SCW'(STACK_DEPTH));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    idle |=> !out_valid);

  assert_end_handoff_R6: assert property (@(posedge clk) disable iff (rst)
    (is_end && !fifo_empty) |=> !idle);

  assert_end_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (is_end && fifo_empty) |=> idle);

  assert_idle_start_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && !fifo_empty) |=> !idle);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (entry_full && !fifo_pop) |=> entry_full);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_overflow || ev_underflow) |=> err);

  assert_overflow_full_R9: assert property (@(posedge clk) disable iff (rst)
    ev_overflow |-> (stk_count == SCW'(STACK_DEPTH)));
endmodule

bind seq_core seq_core_chk #(.STACK_DEPTH(STACK_DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .idle(idle), .out_valid(out_valid), .out_data(out_data),
  .err(err), .entry_full(entry_full), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .is_end(is_end), .ev_overflow(ev_overflow), .ev_underflow(ev_underflow),
  .stk_count(stk_count)
);

// File: tb/sim_seq_core.sv
module sim_seq_core;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int DW = 9;
  localparam int IW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [IW-1:0] prog_data = '0;
  logic entry_push = 1'b0;
  logic [AW-1:0] entry_addr = '0;
  logic entry_full, out_valid, idle, err;
  logic [DW-1:0] out_data;

  seq_core u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .entry_push(entry_push), .entry_addr(entry_addr),
    .entry_full(entry_full), .out_data(out_data), .out_valid(out_valid),
    .idle(idle), .err(err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // monitor, samples at the falling edge
  bit mon_on = 1'b0;
  int nev = 0;
  int ev_val [256];
  int ev_cyc [256];
  int rise_cyc = -1;
  logic prev_idle = 1'b1;
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (nev < 256) begin
          ev_val[nev] = int'(out_data);
          ev_cyc[nev] = cyc;
        end
        nev = nev + 1;
      end
      if (idle && !prev_idle && rise_cyc < 0) rise_cyc = cyc;
      prev_idle = idle;
    end
  end

  // expected trace built from the routine shapes
  int exp_n = 0;
  int exp_val [256];
  int exp_off [256];
  int base = 0;

  task automatic exp_clear();
    exp_n = 0;
    base = 0;
  endtask

  task automatic add_emit(input int v, input int off);
    exp_val[exp_n] = v;
    exp_off[exp_n] = off;
    exp_n = exp_n + 1;
  endtask

  task automatic add_left();
    for (int k = 0; k < 4; k++) add_emit(1 << k, base + k);
    base = base + 5;
  endtask

  task automatic add_right();
    for (int k = 0; k < 4; k++) add_emit(8 >> k, base + k);
    base = base + 5;
  endtask

  task automatic add_multi(input int n);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 4; k++) add_emit(1 << k, base + 2 + 7*i + k);
    base = base + 2 + 7*n;
  endtask

  task automatic add_jump();
    add_emit(1, base + 1);
    base = base + 3;
  endtask

  task automatic add_end();
    base = base + 1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_ins(input int a, input int op, input int dv);
    prog_we = 1'b1;
    prog_addr = AW'(a);
    prog_data = {3'(op), DW'(dv)};
    tick();
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic mon_start();
    nev = 0;
    rise_cyc = -1;
    prev_idle = idle;
    mon_on = 1'b1;
  endtask

  task automatic wait_idle();
    int w = 0;
    while (rise_cyc < 0 && w < 3000) begin
      tick();
      w++;
    end
    if (rise_cyc < 0) chk("R6 routine never finished", 0, 1);
    tick();
    tick();
    mon_on = 1'b0;
  endtask

  int qa [16];
  int push_cyc = 0;

  task automatic run_queue(input int n);
    mon_start();
    for (int i = 0; i < n; i++) begin
      if (i == 0) push_cyc = cyc;
      entry_push = 1'b1;
      entry_addr = AW'(qa[i]);
      tick();
    end
    entry_push = 1'b0;
    wait_idle();
  endtask

  task automatic compare_trace();
    chk("R6 emit count", nev, exp_n);
    for (int k = 0; k < exp_n && k < nev; k++) begin
      chk("R2 emitted value", ev_val[k], exp_val[k]);
      chk("R6 emit cycle offset", ev_cyc[k] - ev_cyc[0], exp_off[k] - exp_off[0]);
    end
    if (nev > 0) begin
      chk("R6 idle after last finish", rise_cyc - ev_cyc[0], (base - 1) - exp_off[0]);
      chk("R2 output held when idle", int'(out_data), exp_val[exp_n-1]);
    end
    chk("R6 no valid while idle", int'(out_valid), 0);
  endtask

  // watchdog
  initial begin
    #(CLK_P * 150000);
    checks = checks + 1;
    fails = fails + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 idle", int'(idle), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 entry_full", int'(entry_full), 0);

    // program: op 0 emit,1 push,2 loop,3 jmp,4 call,5 ret,6 pop,7 finish
    for (int a = 0; a < 32; a++) wr_ins(a, 7, 0);
    wr_ins(1, 0, 1); wr_ins(2, 0, 2); wr_ins(3, 0, 4); wr_ins(4, 0, 8); wr_ins(5, 7, 0);
    wr_ins(6, 0, 8); wr_ins(7, 0, 4); wr_ins(8, 0, 2); wr_ins(9, 0, 1); wr_ins(10, 7, 0);
    wr_ins(11, 1, 3); wr_ins(12, 4, 20); wr_ins(13, 2, 12); wr_ins(14, 7, 0);
    wr_ins(15, 3, 9);
    wr_ins(16, 6, 0); wr_ins(17, 7, 0);
    wr_ins(20, 0, 1); wr_ins(21, 0, 2); wr_ins(22, 0, 4); wr_ins(23, 0, 8); wr_ins(24, 5, 0);
    for (int a = 25; a < 30; a++) wr_ins(a, 1, 1);
    wr_ins(30, 7, 0);

    // R3 R4 R5 R6: five routines queued back to back
    exp_clear();
    add_left(); add_multi(3); add_right(); add_jump(); add_left();
    qa[0] = 1; qa[1] = 11; qa[2] = 6; qa[3] = 15; qa[4] = 1;
    run_queue(5);
    compare_trace();
    chk("R7 start latency from idle", ev_cyc[0] - push_cyc, 3);
    chk("R9 no fault, err clear", int'(err), 0);

    // R3 R5: loop count sweep
    for (int n = 1; n <= 6; n++) begin
      wr_ins(11, 1, n);
      exp_clear();
      add_multi(n);
      qa[0] = 11;
      run_queue(1);
      compare_trace();
      chk("R7 first emit of counted routine", ev_cyc[0] - push_cyc, 5);
    end

    // R8: fill the queue behind a long routine, then one dropped write
    exp_clear();
    add_multi(6);
    for (int i = 0; i < 8; i++) add_end();
    mon_start();
    entry_push = 1'b1;
    entry_addr = AW'(11);
    tick();
    entry_push = 1'b0;
    tick();
    tick();
    for (int i = 0; i < 8; i++) begin
      entry_push = 1'b1;
      entry_addr = '0;
      tick();
    end
    entry_push = 1'b0;
    chk("R8 full after FIFO_DEPTH writes", int'(entry_full), 1);
    entry_push = 1'b1;
    entry_addr = AW'(1);
    tick();
    entry_push = 1'b0;
    chk("R8 still full after dropped write", int'(entry_full), 1);
    wait_idle();
    compare_trace();
    chk("R8 queue drained", int'(entry_full), 0);

    // R9: underflow, stickiness, reset clears
    do_reset();
    chk("R1 err after reset", int'(err), 0);
    exp_clear();
    qa[0] = 16;
    run_queue(1);
    chk("R9 underflow sets err", int'(err), 1);
    exp_clear();
    add_left();
    qa[0] = 1;
    run_queue(1);
    compare_trace();
    chk("R9 err sticky", int'(err), 1);
    do_reset();
    chk("R1 err cleared", int'(err), 0);
    chk("R1 idle after reset", int'(idle), 1);

    // R9: overflow on a stack of depth 4
    qa[0] = 25;
    run_queue(1);
    chk("R9 overflow sets err", int'(err), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule